// File: doc/BRIEF.md
# Graphics Command Decoder and Dispatcher

This block sits between a processor output port and the drawing hardware of a display subsystem. The processor presents a 16-bit command word together with a separate valid bit. The block decodes the word, keeps the operands of drawing commands in internal registers, and launches the requested action. It then raises a complete flag that stays up until the processor lowers valid. A command is taken only on a fresh rising edge of valid, so each command runs exactly once.

Two kinds of work stay inside the block. Single-pixel plots and full-screen clears go out through a framebuffer write port that is addressed by X and Y. Line and character drawing go to external engines. Each engine gets a one-cycle start pulse with its operands and an 8-bit colour attached. The block waits for the engine's done pulse before it reports completion. The colour byte is carried unchanged; its layout is two bits each of red, green and blue in bits 7..2, and bits 1..0 are unused.

Top module: `gfx_cmd_dispatch`

## Requirements
- R1: The command word carries the opcode in bits 15..10 and the data in bits 9..0. Opcodes 0, 1, 2 and 3 load data[9:0] into X1, Y1, X2 and Y2. Complete is high at the first sample after the accepting clock edge.
- R2: Opcode 4 loads data[7:0] into the character register and completes in one cycle.
- R3: Opcode 7 makes exactly one framebuffer write at (X1, Y1) with colour data[7:0], in the cycle after acceptance. Complete rises one cycle later.
- R4: Opcode 6 raises line_start_o for exactly one cycle, in the cycle after acceptance, with X1, Y1, X2, Y2 and colour data[7:0] on the line operand ports. Complete rises in the cycle after line_done_i is sampled high.
- R5: Opcode 5 raises chr_start_o for exactly one cycle, with the character register, X1, Y1 and colour data[7:0] on the character operand ports. Complete rises in the cycle after chr_done_i is sampled high.
- R6: Opcode 8 writes colour 0 to all SCR_W*SCR_H locations, one per clock. The order is X fastest, from (0,0) to (SCR_W-1, SCR_H-1). Complete rises in the cycle after the last write.
- R7: Complete stays high while valid stays high, and it is low in the cycle after valid is sampled low.
- R8: A command is accepted only when valid is sampled high after having been sampled low at an earlier clock edge. Holding valid high never repeats a command.
- R9: Opcodes 9 to 63 complete in one cycle. They write nothing, start no engine and change no register.
- R10: After reset, complete, the framebuffer write strobe and both start pulses are low, and X1, Y1, X2, Y2 and the character register are zero.
- R11: An engine done pulse that arrives while no engine command is pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 16 | Command word: opcode in bits 15..10, data in bits 9..0 |
| cmd_valid_i | input | 1 | Command qualifier from the processor |
| cmd_done_o | output | 1 | Complete flag to the processor |
| fb_we_o | output | 1 | Framebuffer write strobe |
| fb_x_o | output | 10 | Framebuffer write column |
| fb_y_o | output | 10 | Framebuffer write row |
| fb_color_o | output | 8 | Framebuffer write colour |
| line_start_o | output | 1 | Line engine start pulse |
| line_x1_o | output | 10 | Line start column |
| line_y1_o | output | 10 | Line start row |
| line_x2_o | output | 10 | Line end column |
| line_y2_o | output | 10 | Line end row |
| line_color_o | output | 8 | Line colour |
| line_done_i | input | 1 | Line engine done pulse |
| chr_start_o | output | 1 | Character engine start pulse |
| chr_code_o | output | 8 | Character code |
| chr_x_o | output | 10 | Character column |
| chr_y_o | output | 10 | Character row |
| chr_color_o | output | 8 | Character colour |
| chr_done_i | input | 1 | Character engine done pulse |

## Verification
A wrong sequencer state shows up at the ports on the very next clock. It appears as a missing or repeated write strobe, a start pulse longer than one cycle, or a complete flag that rises early, late or not at all. A corrupted operand register stays hidden until the next plot, line or character command, where it appears as a wrong coordinate. For that reason the sequences set registers, run unused opcodes and send stray done pulses, and then issue drawing commands whose outputs must still match. A clear-scan counter fault shows up as a break in the X-fastest order or as a wrong final pixel.

// File: rtl/gfx_cmd_pkg.sv
package gfx_cmd_pkg;
  localparam int CMD_W = 16;
  localparam int OP_W  = 6;
  localparam int DAT_W = CMD_W - OP_W;
  localparam int COL_W = 8;
  localparam int CHR_W = 8;

  localparam logic [OP_W-1:0] OP_SET_X1    = 6'd0;
  localparam logic [OP_W-1:0] OP_SET_Y1    = 6'd1;
  localparam logic [OP_W-1:0] OP_SET_X2    = 6'd2;
  localparam logic [OP_W-1:0] OP_SET_Y2    = 6'd3;
  localparam logic [OP_W-1:0] OP_SET_CHR   = 6'd4;
  localparam logic [OP_W-1:0] OP_DRAW_CHR  = 6'd5;
  localparam logic [OP_W-1:0] OP_DRAW_LINE = 6'd6;
  localparam logic [OP_W-1:0] OP_PLOT      = 6'd7;
  localparam logic [OP_W-1:0] OP_CLEAR     = 6'd8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PIX, ST_LREQ, ST_LWAIT, ST_CREQ, ST_CWAIT, ST_CLR
  } st_e;
endpackage

// File: rtl/gfx_cmd_accept.sv
module gfx_cmd_accept (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic idle_i,
  input  logic finish_i,
  output logic accept_o,
  output logic done_o
);
  logic armed_q, done_q;

  assign accept_o = valid_i & armed_q & idle_i;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (!valid_i)      armed_q <= 1'b1;
      else if (accept_o) armed_q <= 1'b0;
      done_q <= valid_i & (done_q | finish_i);
    end
  end

  a_r7_done_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);
  a_r8_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !accept_o);
endmodule

// File: rtl/gfx_operand_regs.sv
module gfx_operand_regs #(
  parameter int CW = 10,
  parameter int HW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [2:0]    sel_i,
  input  logic [CW-1:0] data_i,
  output logic [CW-1:0] x1_o,
  output logic [CW-1:0] y1_o,
  output logic [CW-1:0] x2_o,
  output logic [CW-1:0] y2_o,
  output logic [HW-1:0] chr_o
);
  localparam int NCRD = 4;
  logic [NCRD-1:0][CW-1:0] crd;
  logic [HW-1:0]           chr_q;

  for (genvar g = 0; g < NCRD; g++) begin : g_crd
    logic [CW-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           r_q <= '0;
      else if (load_i && sel_i == 3'(g))     r_q <= data_i;
    end
    assign crd[g] = r_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          chr_q <= '0;
    else if (load_i && sel_i == 3'(NCRD)) chr_q <= data_i[HW-1:0];
  end

  assign x1_o  = crd[0];
  assign y1_o  = crd[1];
  assign x2_o  = crd[2];
  assign y2_o  = crd[3];
  assign chr_o = chr_q;

  a_r9_regs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(crd) && $stable(chr_q)));
endmodule

// File: rtl/gfx_clear_scan.sv
module gfx_clear_scan #(
  parameter int SCR_W = 640,
  parameter int SCR_H = 480,
  parameter int CW    = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          step_i,
  output logic [CW-1:0] x_o,
  output logic [CW-1:0] y_o,
  output logic          last_o
);
  localparam logic [CW-1:0] X_MAX = CW'(SCR_W - 1);
  localparam logic [CW-1:0] Y_MAX = CW'(SCR_H - 1);

  logic [CW-1:0] x_q, y_q;
  logic          x_end;

  assign x_end  = (x_q == X_MAX);
  assign last_o = x_end && (y_q == Y_MAX);
  assign x_o    = x_q;
  assign y_o    = y_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0;
      y_q <= '0;
    end else if (start_i) begin
      x_q <= '0;
      y_q <= '0;
    end else if (step_i) begin
      if (x_end) begin
        x_q <= '0;
        y_q <= last_o ? '0 : y_q + 1'b1;
      end else begin
        x_q <= x_q + 1'b1;
      end
    end
  end

  a_r6_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_q <= X_MAX) && (y_q <= Y_MAX));
  a_r6_x_fastest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !start_i && !x_end) |=> $stable(y_q));
endmodule

// File: rtl/gfx_cmd_dispatch.sv
module gfx_cmd_dispatch
  import gfx_cmd_pkg::*;
#(
  parameter int SCR_W = 640,
  parameter int SCR_H = 480
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             cmd_valid_i,
  output logic             cmd_done_o,
  output logic             fb_we_o,
  output logic [DAT_W-1:0] fb_x_o,
  output logic [DAT_W-1:0] fb_y_o,
  output logic [COL_W-1:0] fb_color_o,
  output logic             line_start_o,
  output logic [DAT_W-1:0] line_x1_o,
  output logic [DAT_W-1:0] line_y1_o,
  output logic [DAT_W-1:0] line_x2_o,
  output logic [DAT_W-1:0] line_y2_o,
  output logic [COL_W-1:0] line_color_o,
  input  logic             line_done_i,
  output logic             chr_start_o,
  output logic [CHR_W-1:0] chr_code_o,
  output logic [DAT_W-1:0] chr_x_o,
  output logic [DAT_W-1:0] chr_y_o,
  output logic [COL_W-1:0] chr_color_o,
  input  logic             chr_done_i
);
  localparam int CW = DAT_W;

  logic [OP_W-1:0]  op;
  logic [DAT_W-1:0] dat;
  logic             accept, finish, is_load, is_action;
  st_e              st_q;
  logic [COL_W-1:0] col_q;
  logic [CW-1:0]    x1, y1, x2, y2, clr_x, clr_y;
  logic [CHR_W-1:0] chr;
  logic             clr_last;

  assign op  = cmd_i[CMD_W-1:DAT_W];
  assign dat = cmd_i[DAT_W-1:0];

  assign is_load   = (op <= OP_SET_CHR);
  assign is_action = (op == OP_DRAW_CHR) || (op == OP_DRAW_LINE) ||
                     (op == OP_PLOT) || (op == OP_CLEAR);

  gfx_cmd_accept u_accept (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (cmd_valid_i),
    .idle_i   (st_q == ST_IDLE),
    .finish_i (finish),
    .accept_o (accept),
    .done_o   (cmd_done_o)
  );

  gfx_operand_regs #(.CW(CW), .HW(CHR_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept && is_load),
    .sel_i  (op[2:0]),
    .data_i (dat),
    .x1_o   (x1),
    .y1_o   (y1),
    .x2_o   (x2),
    .y2_o   (y2),
    .chr_o  (chr)
  );

  gfx_clear_scan #(.SCR_W(SCR_W), .SCR_H(SCR_H), .CW(CW)) u_scan (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept && op == OP_CLEAR),
    .step_i  (st_q == ST_CLR),
    .x_o     (clr_x),
    .y_o     (clr_y),
    .last_o  (clr_last)
  );

  always_comb begin
    unique case (st_q)
      ST_IDLE:  finish = accept && !is_action;
      ST_PIX:   finish = 1'b1;
      ST_LWAIT: finish = line_done_i;
      ST_CWAIT: finish = chr_done_i;
      ST_CLR:   finish = clr_last;
      default:  finish = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      col_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          col_q <= dat[COL_W-1:0];
          if      (op == OP_PLOT)      st_q <= ST_PIX;
          else if (op == OP_DRAW_LINE) st_q <= ST_LREQ;
          else if (op == OP_DRAW_CHR)  st_q <= ST_CREQ;
          else if (op == OP_CLEAR)     st_q <= ST_CLR;
        end
        ST_PIX:   st_q <= ST_IDLE;
        ST_LREQ:  st_q <= ST_LWAIT;
        ST_LWAIT: if (line_done_i) st_q <= ST_IDLE;
        ST_CREQ:  st_q <= ST_CWAIT;
        ST_CWAIT: if (chr_done_i) st_q <= ST_IDLE;
        ST_CLR:   if (clr_last) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  // framebuffer port shared by plot and clear
  assign fb_we_o    = (st_q == ST_PIX) || (st_q == ST_CLR);
  assign fb_x_o     = (st_q == ST_CLR) ? clr_x : x1;
  assign fb_y_o     = (st_q == ST_CLR) ? clr_y : y1;
  assign fb_color_o = (st_q == ST_CLR) ? '0 : col_q;

  assign line_start_o = (st_q == ST_LREQ);
  assign line_x1_o    = x1;
  assign line_y1_o    = y1;
  assign line_x2_o    = x2;
  assign line_y2_o    = y2;
  assign line_color_o = col_q;

  assign chr_start_o = (st_q == ST_CREQ);
  assign chr_code_o  = chr;
  assign chr_x_o     = x1;
  assign chr_y_o     = y1;
  assign chr_color_o = col_q;

  a_r3_plot_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_we_o && st_q == ST_PIX) |=> !fb_we_o);
  a_r4_line_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_o |=> !line_start_o);
  a_r5_chr_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chr_start_o |=> !chr_start_o);
  a_r6_clear_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CLR && clr_last && cmd_valid_i) |=> (cmd_done_o && !fb_we_o));
  a_r11_busy_no_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !accept) |=> $stable(cmd_done_o) || !$past(cmd_valid_i));
endmodule

// File: tb/gfx_cmd_dispatch_bench.sv
module gfx_cmd_dispatch_bench;
  localparam int W = 16;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cmd = '0;
  logic valid = 1'b0;
  logic ld_stub = 1'b0, ld_stray = 1'b0, cd_stub = 1'b0, cd_stray = 1'b0;
  logic done, fb_we, l_start, c_start;
  logic [9:0] fb_x, fb_y, l_x1, l_y1, l_x2, l_y2, c_x, c_y;
  logic [7:0] fb_col, l_col, c_code, c_col;

  always #2 clk = ~clk;

  gfx_cmd_dispatch #(.SCR_W(W), .SCR_H(H)) u_gfx_cmd_dispatch (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .cmd_valid_i(valid),
    .cmd_done_o(done), .fb_we_o(fb_we), .fb_x_o(fb_x), .fb_y_o(fb_y),
    .fb_color_o(fb_col), .line_start_o(l_start), .line_x1_o(l_x1),
    .line_y1_o(l_y1), .line_x2_o(l_x2), .line_y2_o(l_y2),
    .line_color_o(l_col), .line_done_i(ld_stub | ld_stray),
    .chr_start_o(c_start), .chr_code_o(c_code), .chr_x_o(c_x),
    .chr_y_o(c_y), .chr_color_o(c_col), .chr_done_i(cd_stub | cd_stray)
  );

  int vecs = 0, miss = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  endtask

  // behavioural reference: mode 0 idle,1 plot,2 line req,3 line wait,4 chr req,5 chr wait,6 clear
  int m_mode, m_cx, m_cy, m_col;
  int m_reg[5];
  bit m_armed, m_done;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_cx = 0; m_cy = 0; m_col = 0;
      foreach (m_reg[i]) m_reg[i] = 0;
      m_armed = 0; m_done = 0;
    end else begin
      bit fin;
      int op, d;
      fin = 0; op = cmd[15:10]; d = cmd[9:0];
      case (m_mode)
        0: if (valid && m_armed) begin
             m_armed = 0;
             if (op <= 3) begin m_reg[op] = d; fin = 1; end
             else if (op == 4) begin m_reg[4] = d % 256; fin = 1; end
             else if (op == 5) begin m_mode = 4; m_col = d % 256; end
             else if (op == 6) begin m_mode = 2; m_col = d % 256; end
             else if (op == 7) begin m_mode = 1; m_col = d % 256; end
             else if (op == 8) begin m_mode = 6; m_cx = 0; m_cy = 0; end
             else fin = 1;
           end
        1: begin fin = 1; m_mode = 0; end
        2: m_mode = 3;
        3: if (ld_stub | ld_stray) begin fin = 1; m_mode = 0; end
        4: m_mode = 5;
        5: if (cd_stub | cd_stray) begin fin = 1; m_mode = 0; end
        6: if (m_cx == W-1 && m_cy == H-1) begin fin = 1; m_mode = 0; end
           else if (m_cx == W-1) begin m_cx = 0; m_cy++; end
           else m_cx++;
        default: m_mode = 0;
      endcase
      if (!valid) m_armed = 1;
      m_done = valid ? (m_done | fin) : 1'b0;
    end
  end

  // per-cycle comparison and output monitors
  int wr_cnt = 0, nz_cnt = 0, last_wx = -1, last_wy = -1, first_wx = -1, first_wy = -1;
  int ls_cnt = 0, cs_cnt = 0;
  bit want_first = 0;
  int cap_l[5], cap_c[4];
  int lcnt = 0, ccnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_we;
      e_we = (m_mode == 1 || m_mode == 6);
      chk(done == m_done, "R7 done", done, m_done);
      chk(fb_we == e_we, "R3/R6 fb_we", fb_we, e_we);
      chk(l_start == (m_mode == 2), "R4 line_start", l_start, m_mode == 2);
      chk(c_start == (m_mode == 4), "R5 chr_start", c_start, m_mode == 4);
      if (fb_we && e_we) begin
        chk(fb_x == (m_mode == 6 ? m_cx : m_reg[0]), "R3/R6 fb_x", fb_x, m_mode == 6 ? m_cx : m_reg[0]);
        chk(fb_y == (m_mode == 6 ? m_cy : m_reg[1]), "R3/R6 fb_y", fb_y, m_mode == 6 ? m_cy : m_reg[1]);
        chk(fb_col == (m_mode == 6 ? 0 : m_col), "R3/R6 fb_color", fb_col, m_mode == 6 ? 0 : m_col);
      end
      if (l_start) begin
        chk(l_x1 == m_reg[0] && l_y1 == m_reg[1] && l_x2 == m_reg[2] && l_y2 == m_reg[3],
            "R4 line operands", {l_x1, l_y1, l_x2, l_y2},
            {10'(m_reg[0]), 10'(m_reg[1]), 10'(m_reg[2]), 10'(m_reg[3])});
        chk(l_col == m_col, "R4 line colour", l_col, m_col);
      end
      if (c_start) begin
        chk(c_code == m_reg[4] && c_x == m_reg[0] && c_y == m_reg[1], "R5 chr operands",
            {c_code, c_x, c_y}, {8'(m_reg[4]), 10'(m_reg[0]), 10'(m_reg[1])});
        chk(c_col == m_col, "R5 chr colour", c_col, m_col);
      end
    end
    if (fb_we) begin
      wr_cnt++; last_wx = fb_x; last_wy = fb_y;
      if (fb_col != 0) nz_cnt++;
      if (want_first) begin first_wx = fb_x; first_wy = fb_y; want_first = 0; end
    end
    if (l_start) begin ls_cnt++; cap_l = '{l_x1, l_y1, l_x2, l_y2, l_col}; end
    if (c_start) begin cs_cnt++; cap_c = '{c_code, c_x, c_y, c_col}; end
    // engine stubs: done pulse three cycles after start
    ld_stub = 0; cd_stub = 0;
    if (lcnt > 0) begin lcnt--; if (lcnt == 0) ld_stub = 1; end
    if (ccnt > 0) begin ccnt--; if (ccnt == 0) cd_stub = 1; end
    if (l_start) lcnt = 3;
    if (c_start) ccnt = 3;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      miss++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      report();
    end
  end

  task automatic send(input int op, input int d, input int hold, output int lat);
    @(negedge clk);
    cmd = {6'(op), 10'(d)}; valid = 1;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!done);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(done == 1, "R7 done held", done, 1);
    end
    valid = 0;
    @(negedge clk);
    chk(done == 0, "R7 done cleared", done, 0);
  endtask

  initial begin
    int lat, w0, s0, c0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(done == 0 && fb_we == 0 && l_start == 0 && c_start == 0, "R10 reset outputs",
        {done, fb_we, l_start, c_start}, 0);

    send(6, 8'h00, 0, lat);
    chk(cap_l[0] == 0 && cap_l[1] == 0 && cap_l[2] == 0 && cap_l[3] == 0, "R10 regs zero",
        cap_l[0] + cap_l[1] + cap_l[2] + cap_l[3], 0);
    chk(lat == 5, "R4 line latency", lat, 5);

    send(0, 5, 0, lat);   chk(lat == 1, "R1 set X1 latency", lat, 1);
    send(1, 3, 0, lat);   chk(lat == 1, "R1 set Y1 latency", lat, 1);
    send(2, 12, 0, lat);
    send(3, 999, 0, lat);
    send(4, 10'h241, 0, lat); chk(lat == 1, "R2 set char latency", lat, 1);

    w0 = wr_cnt;
    send(7, 10'h3E4, 0, lat);
    chk(wr_cnt - w0 == 1, "R3 one write", wr_cnt - w0, 1);
    chk(last_wx == 5 && last_wy == 3, "R3 write position", last_wx * 1000 + last_wy, 5003);
    chk(lat == 2, "R3 plot latency", lat, 2);

    send(6, 8'h1C, 0, lat);
    chk(cap_l[0] == 5 && cap_l[1] == 3 && cap_l[2] == 12 && cap_l[3] == 999, "R4 operands",
        cap_l[3], 999);
    chk(cap_l[4] == 8'h1C, "R4 colour", cap_l[4], 8'h1C);

    send(5, 8'h03, 0, lat);
    chk(cap_c[0] == 8'h41 && cap_c[1] == 5 && cap_c[2] == 3, "R5 operands", cap_c[0], 8'h41);
    chk(cap_c[3] == 3 && lat == 5, "R5 colour/latency", lat, 5);

    w0 = wr_cnt; s0 = ls_cnt; c0 = cs_cnt;
    send(9, 10'h3FF, 0, lat);  chk(lat == 1, "R9 opcode 9 latency", lat, 1);
    send(63, 10'h3FF, 0, lat); chk(lat == 1, "R9 opcode 63 latency", lat, 1);
    chk(wr_cnt == w0 && ls_cnt == s0 && cs_cnt == c0, "R9 no side effects",
        wr_cnt - w0 + ls_cnt - s0 + cs_cnt - c0, 0);
    send(7, 8'h80, 0, lat);
    chk(last_wx == 5 && last_wy == 3, "R9 regs unchanged", last_wx * 1000 + last_wy, 5003);

    w0 = wr_cnt;
    send(7, 8'h44, 6, lat);
    repeat (4) @(negedge clk);
    chk(wr_cnt - w0 == 1, "R8 held valid single write", wr_cnt - w0, 1);

    s0 = ls_cnt; c0 = cs_cnt;
    @(negedge clk); ld_stray = 1; cd_stray = 1;
    @(negedge clk); ld_stray = 0; cd_stray = 0;
    repeat (3) @(negedge clk);
    chk(done == 0 && ls_cnt == s0 && cs_cnt == c0, "R11 stray done ignored", done, 0);
    send(6, 8'h10, 0, lat);
    chk(lat == 5, "R11 line after stray", lat, 5);

    w0 = wr_cnt; nz_cnt = 0; want_first = 1;
    send(8, 0, 0, lat);
    chk(wr_cnt - w0 == W * H, "R6 write count", wr_cnt - w0, W * H);
    chk(first_wx == 0 && first_wy == 0, "R6 first pixel", first_wx * 1000 + first_wy, 0);
    chk(last_wx == W-1 && last_wy == H-1, "R6 last pixel", last_wx * 1000 + last_wy, (W-1) * 1000 + H-1);
    chk(nz_cnt == 0, "R6 colour zero", nz_cnt, 0);
    chk(lat == W * H + 1, "R6 latency", lat, W * H + 1);

    send(7, 8'hFC, 0, lat);
    chk(last_wx == 5 && last_wy == 3, "R1 coords survive clear", last_wx * 1000 + last_wy, 5003);

    repeat (4) @(negedge clk);
    report();
  end
endmodule